// File: doc/BRIEF.md
# Serial Control Port with Burst Register Loading

This block is the slave side of a three-wire serial control port. A host lowers an active-low load strobe, toggles a serial clock and presents one bit on the data line for each rising clock edge. A frame opens with a direction flag, a test bit and a three-bit register address. Data bits follow. The port feeds a bank of five configuration registers, and each register has its own fixed width. The serial inputs are oversampled by a system clock, so the edge detection, shifting, decode and commit logic all sit in one clock domain.

Write data lands in shadow registers first. The active outputs change only when the load strobe returns high. At that point every register that was completely received in the frame updates together. A write frame may carry more than one register. When a register has received exactly its own bit count, the following bits fill the next higher address, and this continues up to the last implemented address. A read frame selects one register and shifts its active value out on the data line, lowest bit first. The output changes on falling serial clock edges. The output enable is asserted only during the data phase of a valid read.

Top module: `ser_reg_port`

## Requirements
- R1: After reset every active register is zero, except register 0, which resets to 0x004 (bit 2 set). The data output enable is low.
- R2: A bit is taken from sdio_i on each rising edge of sclk_i while load_ni is low. The frame order is: a direction flag (0 write, 1 read), a test bit, address bits A0, A1, A2 (least significant first), then data bits, least significant first.
- R3: Addresses 0, 1, 2, 3 and 4 hold registers of 11, 10, 8, 10 and 6 bits.
- R4: While load_ni stays low, the active outputs do not change. When load_ni rises, every register fully received in the frame updates in the same clock cycle.
- R5: In a write frame, once a register's exact bit count has arrived, the following bits load the next higher address. After register 4 is complete, further bits are ignored.
- R6: A register whose data bits are cut short by load_ni rising keeps its previous active value.
- R7: Writes to addresses 5 to 7 change no register. This includes a burst that starts at one of those addresses.
- R8: A frame whose test bit is 1 changes no register and never enables the data output.
- R9: In a read frame, the bit shown after the k-th falling sclk_i edge (k ≥ 5) is bit k−5 of the selected active register. Bits beyond the register width read as 0, and addresses 5 to 7 read as all zeros.
- R10: sdio_oe_o is high only in the data phase of a read frame whose test bit is 0, and it drops within two clock cycles of load_ni rising. A read frame changes no register.
- R11: Serial clock edges while load_ni is high have no effect on later frames or on the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| load_ni | input | 1 | Active-low frame strobe; its rising edge commits the loaded registers |
| sdio_i | input | 1 | Serial data input |
| sdio_o | output | 1 | Serial readback data |
| sdio_oe_o | output | 1 | Drive enable for the shared data line |
| cfg0_o | output | 11 | Active register 0 |
| cfg1_o | output | 10 | Active register 1 |
| cfg2_o | output | 8 | Active register 2 |
| cfg3_o | output | 10 | Active register 3 |
| cfg4_o | output | 6 | Active register 4 |

## Verification
A corrupted bit counter or address pointer shows up as a wrong value at one or more cfg outputs. It appears in the cycle after load_ni rises, or earlier, as a wrong readback bit after the fifth falling serial edge. Shadow values that leak into the active registers are caught while the strobe is still low. The bench compares every output before each commit as well as after it. Random burst frames that start at every address, with truncated tails and test bits set, are checked against a bench model of the register widths. Together they show an off-by-one at any width boundary within a single frame.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int NREG = 5;
  localparam int AW   = 3;
  localparam int W0   = 11;
  localparam int W1   = 10;
  localparam int W2   = 8;
  localparam int W3   = 10;
  localparam int W4   = 6;
  localparam int MAXW = 11;
  localparam int CW   = $clog2(MAXW + 1);
  localparam int BCW  = 6;
  localparam logic [MAXW-1:0] RST0 = MAXW'(4);

  function automatic int unsigned reg_width(input logic [AW-1:0] a);
    case (a)
      3'd0:    return W0;
      3'd1:    return W1;
      3'd2:    return W2;
      3'd3:    return W3;
      3'd4:    return W4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [MAXW-1:0] reg_reset(input int idx);
    return (idx == 0) ? RST0 : '0;
  endfunction
endpackage

// File: rtl/srp_edge.sv
module srp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic load_ni,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic load_rise_o
);
  logic sclk_q, load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      load_q <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      load_q <= load_ni;
    end
  end

  assign sclk_rise_o = sclk_i & ~sclk_q & ~load_ni;
  assign sclk_fall_o = ~sclk_i & sclk_q & ~load_ni;
  assign load_rise_o = load_ni & ~load_q;

  assert_edges_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni |-> !(sclk_rise_o || sclk_fall_o));
endmodule

// File: rtl/srp_frame.sv
module srp_frame
  import ser_reg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            idle_i,
  input  logic            sdi_i,
  input  logic [MAXW-1:0] rd_word_i,
  output logic            wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [MAXW-1:0] wr_data_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic            sdo_o,
  output logic            oe_o
);
  logic [BCW-1:0]  bit_cnt_q;
  logic            rnw_q, tst_q, done_q;
  logic [AW-1:0]   addr_q, cur_q;
  logic [CW-1:0]   dcnt_q;
  logic [MAXW-1:0] shreg_q;
  logic            wr_q;
  logic [AW-1:0]   wr_addr_q;
  logic [MAXW-1:0] wr_data_q;
  logic            sdo_q, oe_q;

  logic            hdr_done, load_ok, last_bit;
  logic [CW-1:0]   cur_w_m1;
  logic [MAXW-1:0] nxt_word, rd_shift;
  logic [BCW-1:0]  rd_idx;

  assign hdr_done = bit_cnt_q >= BCW'(AW + 2);
  assign load_ok  = hdr_done & ~rnw_q & ~tst_q & ~done_q & (cur_q < AW'(NREG));
  assign cur_w_m1 = CW'(reg_width(cur_q) - 1);
  assign last_bit = dcnt_q == cur_w_m1;
  assign nxt_word = shreg_q | (MAXW'(sdi_i) << dcnt_q);
  assign rd_idx   = bit_cnt_q - BCW'(AW + 2);
  assign rd_shift = rd_word_i >> rd_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0; rnw_q <= 1'b0; tst_q <= 1'b0; done_q <= 1'b0;
      addr_q <= '0; cur_q <= '0; dcnt_q <= '0; shreg_q <= '0;
      wr_q <= 1'b0; wr_addr_q <= '0; wr_data_q <= '0;
      sdo_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (idle_i) begin
        bit_cnt_q <= '0; rnw_q <= 1'b0; tst_q <= 1'b0; done_q <= 1'b0;
        addr_q <= '0; cur_q <= '0; dcnt_q <= '0; shreg_q <= '0;
        sdo_q <= 1'b0; oe_q <= 1'b0;
      end else begin
        if (rise_i) begin
          if (bit_cnt_q != '1) bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == BCW'(0)) begin
            rnw_q <= sdi_i;
          end else if (bit_cnt_q == BCW'(1)) begin
            tst_q <= sdi_i;
          end else if (!hdr_done) begin
            // address arrives LSB first: shift in at the top
            addr_q <= {sdi_i, addr_q[AW-1:1]};
            cur_q  <= {sdi_i, addr_q[AW-1:1]};
          end else if (load_ok) begin
            if (last_bit) begin
              wr_q      <= 1'b1;
              wr_addr_q <= cur_q;
              wr_data_q <= nxt_word;
              shreg_q   <= '0;
              dcnt_q    <= '0;
              if (cur_q == AW'(NREG - 1)) done_q <= 1'b1;
              else                        cur_q  <= cur_q + 1'b1;
            end else begin
              shreg_q <= nxt_word;
              dcnt_q  <= dcnt_q + 1'b1;
            end
          end
        end
        if (fall_i && hdr_done && rnw_q && !tst_q) begin
          oe_q  <= 1'b1;
          sdo_q <= rd_shift[0];
        end
      end
    end
  end

  assign wr_en_o   = wr_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign rd_addr_o = addr_q;
  assign sdo_o     = sdo_q;
  assign oe_o      = oe_q;

  assert_write_needs_write_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> (!tst_q && !rnw_q));
  assert_write_addr_implemented_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> (wr_addr_q < AW'(NREG)));
  assert_oe_only_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (rnw_q && !tst_q));
  assert_oe_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && $past(idle_i)) |-> !oe_q);
  assert_dcnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcnt_q < CW'(MAXW));
endmodule

// File: rtl/srp_bank.sv
module srp_bank
  import ser_reg_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [MAXW-1:0]           wr_data_i,
  input  logic                      commit_i,
  input  logic                      idle_i,
  input  logic [AW-1:0]             rd_addr_i,
  output logic [NREG-1:0][MAXW-1:0] act_o,
  output logic [MAXW-1:0]           rd_word_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int W = reg_width(AW'(g));
    localparam logic [MAXW-1:0] RV = reg_reset(g);
    logic [W-1:0] shadow_q, act_q;
    logic         pend_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= RV[W-1:0];
        act_q    <= RV[W-1:0];
        pend_q   <= 1'b0;
      end else begin
        if (wr_en_i && wr_addr_i == AW'(g)) begin
          shadow_q <= wr_data_i[W-1:0];
          pend_q   <= 1'b1;
        end else if (idle_i) begin
          pend_q <= 1'b0;
        end
        if (commit_i && pend_q) act_q <= shadow_q;
      end
    end

    assign act_o[g] = MAXW'(act_q);
  end

  always_comb begin
    rd_word_o = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr_i == AW'(i)) rd_word_o = act_o[i];
  end

  assert_active_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_o));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_reg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          load_ni,
  input  logic          sdio_i,
  output logic          sdio_o,
  output logic          sdio_oe_o,
  output logic [W0-1:0] cfg0_o,
  output logic [W1-1:0] cfg1_o,
  output logic [W2-1:0] cfg2_o,
  output logic [W3-1:0] cfg3_o,
  output logic [W4-1:0] cfg4_o
);
  logic                      rise, fall, commit;
  logic                      wr_en;
  logic [AW-1:0]             wr_addr, rd_addr;
  logic [MAXW-1:0]           wr_data, rd_word;
  logic [NREG-1:0][MAXW-1:0] act;

  srp_edge u_edge (
    .clk_i, .rst_ni, .sclk_i, .load_ni,
    .sclk_rise_o(rise), .sclk_fall_o(fall), .load_rise_o(commit)
  );

  srp_frame u_frame (
    .clk_i, .rst_ni,
    .rise_i(rise), .fall_i(fall), .idle_i(load_ni), .sdi_i(sdio_i),
    .rd_word_i(rd_word),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .sdo_o(sdio_o), .oe_o(sdio_oe_o)
  );

  srp_bank u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .commit_i(commit), .idle_i(load_ni), .rd_addr_i(rd_addr),
    .act_o(act), .rd_word_o(rd_word)
  );

  assign cfg0_o = act[0][W0-1:0];
  assign cfg1_o = act[1][W1-1:0];
  assign cfg2_o = act[2][W2-1:0];
  assign cfg3_o = act[3][W3-1:0];
  assign cfg4_o = act[4][W4-1:0];

  assert_oe_low_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni)) |-> !sdio_oe_o);
endmodule

// File: tb/ser_reg_port_test.sv
module ser_reg_port_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0, load_ni = 1'b1, sdio_i = 1'b0;
  logic sdio_o, sdio_oe_o;
  logic [10:0] cfg0_o;
  logic [9:0]  cfg1_o;
  logic [7:0]  cfg2_o;
  logic [9:0]  cfg3_o;
  logic [5:0]  cfg4_o;

  int total = 0, bad = 0;
  bit fin = 1'b0;
  logic [10:0] exp_act [5];

  always #(CLK_P/2) clk = ~clk;

  ser_reg_port uut (
    .clk_i(clk), .rst_ni, .sclk_i, .load_ni, .sdio_i,
    .sdio_o, .sdio_oe_o,
    .cfg0_o, .cfg1_o, .cfg2_o, .cfg3_o, .cfg4_o
  );

  function automatic int bw(input int a);
    case (a)
      0: return 11;
      1: return 10;
      2: return 8;
      3: return 10;
      4: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic check_regs(input string req);
    chk(req, "cfg0", 32'(cfg0_o), 32'(exp_act[0]));
    chk(req, "cfg1", 32'(cfg1_o), 32'(exp_act[1]));
    chk(req, "cfg2", 32'(cfg2_o), 32'(exp_act[2]));
    chk(req, "cfg3", 32'(cfg3_o), 32'(exp_act[3]));
    chk(req, "cfg4", 32'(cfg4_o), 32'(exp_act[4]));
  endtask

  // shifts n bits; smp/oes record the data line during each low phase
  task automatic run(input logic [63:0] bits, input int n,
                     output logic [63:0] smp, output logic [63:0] oes);
    smp = '0; oes = '0;
    @(negedge clk); load_ni = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk_i = 1'b0; sdio_i = bits[i];
      repeat (4) @(negedge clk);
      smp[i] = sdio_o; oes[i] = sdio_oe_o;
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_frame();
    load_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_frame(input int a, input int k, input int p, input bit tst,
                          input string req);
    logic [63:0] bits, s, o, msk;
    logic [10:0] nxt [5];
    logic [31:0] v;
    int n, r, w;
    nxt = exp_act;
    bits = '0;
    bits[1] = tst; bits[2] = a[0]; bits[3] = a[1]; bits[4] = a[2];
    n = 5; r = a;
    for (int j = 0; j < k; j++) begin
      w = (r <= 4) ? bw(r) : 7;
      v = $urandom;
      for (int b = 0; b < w; b++) begin bits[n] = v[b]; n++; end
      if (r <= 4 && !tst) nxt[r] = 11'(v & ((32'd1 << w) - 1));
      r++;
    end
    for (int b = 0; b < p; b++) begin bits[n] = 1'($urandom); n++; end
    run(bits, n, s, o);
    msk = (64'd1 << n) - 1;
    chk("R10", "oe during write", 32'(|(o & msk)), 32'd0);
    check_regs("R4");
    end_frame();
    exp_act = nxt;
    check_regs(req);
  endtask

  task automatic rd_frame(input int a, input bit tst, input string req);
    logic [63:0] bits, s, o;
    bit eo;
    logic eb;
    bits = '0;
    bits[0] = 1'b1; bits[1] = tst; bits[2] = a[0]; bits[3] = a[1]; bits[4] = a[2];
    run(bits, 17, s, o);
    for (int i = 0; i < 17; i++) begin
      eo = !tst && i >= 5;
      chk(req, "read oe", 32'(o[i]), 32'(eo));
      if (eo) begin
        eb = (a <= 4 && (i - 5) < bw(a)) ? exp_act[a][i-5] : 1'b0;
        chk(req, "read bit", 32'(s[i]), 32'(eb));
      end
    end
    end_frame();
    chk("R10", "oe after strobe", 32'(sdio_oe_o), 32'd0);
    check_regs("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a, k, p;
    void'($urandom(32'd2024));
    exp_act[0] = 11'h004;
    for (int i = 1; i < 5; i++) exp_act[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_regs("R1");
    chk("R1", "oe reset", 32'(sdio_oe_o), 32'd0);

    wr_frame(2, 1, 0, 1'b0, "R2");
    wr_frame(0, 4, 0, 1'b0, "R5");
    wr_frame(0, 5, 0, 1'b0, "R3");
    wr_frame(1, 1, 5, 1'b0, "R6");
    wr_frame(4, 1, 3, 1'b0, "R6");
    wr_frame(3, 4, 0, 1'b0, "R5");
    wr_frame(6, 2, 0, 1'b0, "R7");
    wr_frame(5, 1, 2, 1'b0, "R7");
    wr_frame(0, 3, 0, 1'b1, "R8");
    rd_frame(1, 1'b1, "R8");
    for (int i = 0; i < 8; i++) rd_frame(i, 1'b0, "R9");

    // idle serial activity must not disturb anything (R11)
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); sdio_i = 1'b1; sclk_i = ~sclk_i;
      repeat (3) @(negedge clk);
    end
    sclk_i = 1'b0;
    repeat (2) @(negedge clk);
    check_regs("R11");
    wr_frame(4, 1, 0, 1'b0, "R11");

    for (int it = 0; it < 50; it++) begin
      if ($urandom % 3 == 0) begin
        rd_frame(int'($urandom % 8), ($urandom % 8) == 0, "R9");
      end else begin
        a = int'($urandom % 8);
        k = int'($urandom % 6);
        p = int'($urandom % 4);
        wr_frame(a, k, p, ($urandom % 8) == 0, "R5");
      end
    end

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule